// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block is the reset controller of a small 8-bit microcontroller. It takes five reset requests: power-on/brown-out, watchdog expiry, an active-low external reset pin, a reset bit written by the debugger, and an active-low debug pin. Whether a request is accepted depends on the current operating mode (normal, halt or stop). Power-on/brown-out is accepted in every mode and wins over all other sources. An accepted request starts a hold sequence. The sequence first counts slow-oscillator periods while the system clock is gated off. It then counts system-clock cycles with the clock running. During both phases the core reset and the GPIO default-state force are held.

When the hold ends, core reset is released. The block then reads the two-byte reset vector with two read strobes and issues a one-cycle program-counter load carrying the assembled address. A reset started by the debug-control bit leaves the debug unit out of reset. Every other cause resets the debug unit as well. A one-hot cause register records the source that started the most recent sequence.

All logic runs on one fast clock. The slow oscillator appears as a one-cycle `osc_tick` enable, and the system-clock gate appears as the `sysclk_en` output. Asynchronous request inputs pass through a two-flop synchronizer. The block's own synchronous reset `rst` starts the sequence exactly as a power-on event would.

Top module: `reset_sequencer`

## Requirements
- R1: A power-on/brown-out request (`por_evt`) is accepted in every mode and wins over any simultaneous source. It sets cause bit 0. Asserting `rst` starts the same sequence with cause bit 0 set.
- R2: After acceptance, `core_rst` is high for OSC_CYCLES (66) `osc_tick` pulses and then for SYS_CYCLES (16) clock cycles. It then falls.
- R3: `sysclk_en` is low only during the oscillator-count phase and is high at all other times.
- R4: `gpio_force` is high exactly while `core_rst` is high.
- R5: In a mode other than stop (`op_mode` != 2'b10), the following are accepted: the pin (`ext_rst_n` low), the debug-control bit (`dbg_ctl_rst` high), and watchdog expiry. Watchdog expiry counts only while `wdt_reset_en` is high.
- R6: In stop mode (`op_mode` == 2'b10), the pin and the debug pin (`dbg_pin_n` low) are accepted. Watchdog expiry and the debug-control bit are ignored there. The debug pin is ignored outside stop mode.
- R7: `dbg_rst` follows `core_rst`, except in a sequence started by the debug-control bit, where it stays low. If any other source restarts such a sequence while core reset is still held, `dbg_rst` is asserted as well.
- R8: `rst_cause` is one-hot. Bit 1 means watchdog, bit 2 the pin, bit 3 the debug-control bit and bit 4 the debug pin. Among simultaneous requests the priority is power, pin, watchdog, debug-control, debug pin.
- R9: In the cycle after `core_rst` falls, `vec_rd` is high for two cycles, with `vec_addr` 0x0002 and then 0x0003. `vec_data` is sampled at the end of each strobe cycle.
- R10: The cycle after the second strobe carries a one-cycle `pc_load`. `pc_value` equals {byte at 0x0002, byte at 0x0003}, and holds that value afterwards.
- R11: An accepted request in any phase restarts the sequence from the first oscillator period.
- R12: A request that is present at clock edge k is acted on at edge k+2, so `core_rst` rises after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset; starts a power-on sequence |
| osc_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| op_mode | input | 2 | 00 normal, 01 halt, 10 stop |
| por_evt | input | 1 | Power-on/brown-out request |
| wdt_expired | input | 1 | Watchdog expiry |
| wdt_reset_en | input | 1 | Watchdog configured to reset |
| ext_rst_n | input | 1 | External reset pin, active low |
| dbg_ctl_rst | input | 1 | Debugger reset-control bit |
| dbg_pin_n | input | 1 | Debug pin, active low |
| vec_data | input | 8 | Program-memory byte for the current strobe |
| core_rst | output | 1 | CPU and peripheral reset |
| dbg_rst | output | 1 | Debug-unit reset |
| gpio_force | output | 1 | Forces GPIO to input with pull-ups off |
| sysclk_en | output | 1 | System clock gate |
| vec_rd | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| pc_load | output | 1 | Program-counter load pulse |
| pc_value | output | 16 | Reset vector |
| rst_cause | output | 5 | One-hot cause of the last sequence |

## Verification
A request sampled at edge k changes the outputs right after edge k+2. The phase outputs (`core_rst`, `dbg_rst`, `gpio_force`, `sysclk_en`) change on the edge where the oscillator count completes the 66th tick, and again 16 edges later. The strobes follow on the next two edges, and `pc_load` follows on the edge after those. The bench's behavioural model steps at every rising edge under these same latencies. Every output is compared on the falling edge, half a period after the edge that should have changed it. Vector bytes are driven on that falling edge from the strobe address, so they are stable when the design samples them at the end of the strobe cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NSRC = 5;
  localparam int SRC_PWR  = 0;
  localparam int SRC_WDT  = 1;
  localparam int SRC_PIN  = 2;
  localparam int SRC_DCTL = 3;
  localparam int SRC_DPIN = 4;
  localparam logic [1:0] MODE_STOP = 2'b10;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OSC  = 3'd1,
    PH_SYS  = 3'd2,
    PH_VHI  = 3'd3,
    PH_VLO  = 3'd4,
    PH_LOAD = 3'd5
  } phase_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rstseq_qual.sv
module rstseq_qual
  import rstseq_pkg::*;
(
  input  logic [1:0]      op_mode,
  input  logic [NSRC-1:0] req,
  output logic            hit,
  output logic [NSRC-1:0] winner,
  output logic            spare_dbg
);
  logic            stop;
  logic [NSRC-1:0] allow;
  logic [NSRC-1:0] live;

  always_comb begin
    stop            = (op_mode == MODE_STOP);
    allow           = '0;
    allow[SRC_PWR]  = 1'b1;
    allow[SRC_PIN]  = 1'b1;
    allow[SRC_WDT]  = !stop;
    allow[SRC_DCTL] = !stop;
    allow[SRC_DPIN] = stop;
    live            = req & allow;
  end

  // lowest priority assigned first, higher ones override
  always_comb begin
    winner = '0;
    if (live[SRC_DPIN]) winner = NSRC'(1) << SRC_DPIN;
    if (live[SRC_DCTL]) winner = NSRC'(1) << SRC_DCTL;
    if (live[SRC_WDT])  winner = NSRC'(1) << SRC_WDT;
    if (live[SRC_PIN])  winner = NSRC'(1) << SRC_PIN;
    if (live[SRC_PWR])  winner = NSRC'(1) << SRC_PWR;
    hit       = |live;
    spare_dbg = winner[SRC_DCTL];
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int OSC_CYCLES = 66,
  parameter int SYS_CYCLES = 16,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0002
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_tick,
  input  logic                hit,
  input  logic [NSRC-1:0]     winner,
  input  logic                spare_req,
  input  logic [DATA_W-1:0]   vec_data,
  output logic                core_rst,
  output logic                dbg_rst,
  output logic                gpio_force,
  output logic                sysclk_en,
  output logic                vec_rd,
  output logic [ADDR_W-1:0]   vec_addr,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_value,
  output logic [NSRC-1:0]     cause
);
  localparam int MAXC  = (OSC_CYCLES > SYS_CYCLES) ? OSC_CYCLES : SYS_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] OSC_LAST = CNT_W'(OSC_CYCLES - 1);
  localparam logic [CNT_W-1:0] SYS_LAST = CNT_W'(SYS_CYCLES - 1);

  phase_e              st, st_n;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic                spare, spare_n;
  logic [NSRC-1:0]     cause_n;
  logic [DATA_W-1:0]   hi, hi_n;
  logic [2*DATA_W-1:0] pc_n;
  logic                hold_n;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    spare_n = spare;
    cause_n = cause;
    hi_n    = hi;
    pc_n    = pc_value;
    if (hit) begin
      st_n    = PH_OSC;
      cnt_n   = '0;
      cause_n = winner;
      spare_n = (st == PH_OSC || st == PH_SYS) ? (spare & spare_req) : spare_req;
    end else begin
      case (st)
        PH_OSC: begin
          if (osc_tick) begin
            if (cnt == OSC_LAST) begin
              st_n  = PH_SYS;
              cnt_n = '0;
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end
        end
        PH_SYS: begin
          if (cnt == SYS_LAST) begin
            st_n  = PH_VHI;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_VHI: begin
          hi_n = vec_data;
          st_n = PH_VLO;
        end
        PH_VLO: begin
          pc_n = {hi, vec_data};
          st_n = PH_LOAD;
        end
        PH_LOAD: st_n = PH_IDLE;
        default: st_n = PH_IDLE;
      endcase
    end
    hold_n = (st_n == PH_OSC) || (st_n == PH_SYS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_OSC;
      cnt        <= '0;
      spare      <= 1'b0;
      cause      <= NSRC'(1) << SRC_PWR;
      hi         <= '0;
      pc_value   <= '0;
      core_rst   <= 1'b1;
      dbg_rst    <= 1'b1;
      gpio_force <= 1'b1;
      sysclk_en  <= 1'b0;
      vec_rd     <= 1'b0;
      vec_addr   <= VEC_BASE;
      pc_load    <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      spare      <= spare_n;
      cause      <= cause_n;
      hi         <= hi_n;
      pc_value   <= pc_n;
      core_rst   <= hold_n;
      gpio_force <= hold_n;
      dbg_rst    <= hold_n & ~spare_n;
      sysclk_en  <= (st_n != PH_OSC);
      vec_rd     <= (st_n == PH_VHI) || (st_n == PH_VLO);
      vec_addr   <= (st_n == PH_VLO) ? VEC_BASE + 1'b1 : VEC_BASE;
      pc_load    <= (st_n == PH_LOAD);
    end
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int OSC_CYCLES  = 66,
  parameter int SYS_CYCLES  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0002
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_tick,
  input  logic [1:0]          op_mode,
  input  logic                por_evt,
  input  logic                wdt_expired,
  input  logic                wdt_reset_en,
  input  logic                ext_rst_n,
  input  logic                dbg_ctl_rst,
  input  logic                dbg_pin_n,
  input  logic [DATA_W-1:0]   vec_data,
  output logic                core_rst,
  output logic                dbg_rst,
  output logic                gpio_force,
  output logic                sysclk_en,
  output logic                vec_rd,
  output logic [ADDR_W-1:0]   vec_addr,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_value,
  output logic [NSRC-1:0]     rst_cause
);
  logic [NSRC-1:0] raw_req, sync_req, winner;
  logic            hit, spare_req;

  always_comb begin
    raw_req           = '0;
    raw_req[SRC_PWR]  = por_evt;
    raw_req[SRC_WDT]  = wdt_expired & wdt_reset_en;
    raw_req[SRC_PIN]  = ~ext_rst_n;
    raw_req[SRC_DCTL] = dbg_ctl_rst;
    raw_req[SRC_DPIN] = ~dbg_pin_n;
  end

  rstseq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (raw_req), .q (sync_req)
  );

  rstseq_qual u_qual (
    .op_mode (op_mode), .req (sync_req), .hit (hit),
    .winner (winner), .spare_dbg (spare_req)
  );

  rstseq_fsm #(
    .OSC_CYCLES (OSC_CYCLES), .SYS_CYCLES (SYS_CYCLES),
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .VEC_BASE (VEC_BASE)
  ) u_fsm (
    .clk (clk), .rst (rst), .osc_tick (osc_tick), .hit (hit),
    .winner (winner), .spare_req (spare_req), .vec_data (vec_data),
    .core_rst (core_rst), .dbg_rst (dbg_rst), .gpio_force (gpio_force),
    .sysclk_en (sysclk_en), .vec_rd (vec_rd), .vec_addr (vec_addr),
    .pc_load (pc_load), .pc_value (pc_value), .cause (rst_cause)
  );
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk (
  input logic        clk,
  input logic        rst,
  input logic        core_rst,
  input logic        dbg_rst,
  input logic        gpio_force,
  input logic        sysclk_en,
  input logic        vec_rd,
  input logic [15:0] vec_addr,
  input logic        pc_load,
  input logic [4:0]  rst_cause
);
  // R7: debug reset never without core reset
  p_dbg_in_core_r7: assert property (@(posedge clk) disable iff (rst)
    dbg_rst |-> core_rst);

  // R3: clock gated only while reset is held
  p_gate_in_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sysclk_en |-> core_rst);

  // R4: GPIO force tracks core reset
  p_gpio_match_r4: assert property (@(posedge clk) disable iff (rst)
    gpio_force == core_rst);

  // R8: cause register stays one-hot
  p_cause_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(rst_cause) == 1);

  // R9: first strobe follows release of core reset and reads the high byte
  p_first_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_rd) |-> ($past(core_rst) && vec_addr == 16'h0002));

  // R10: load pulse is single and follows the low-byte strobe
  p_load_after_lo_r10: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> ($past(vec_rd) && $past(vec_addr) == 16'h0003));

  p_load_single_r10: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load);
endmodule

bind reset_sequencer reset_sequencer_chk u_chk (
  .clk (clk), .rst (rst), .core_rst (core_rst), .dbg_rst (dbg_rst),
  .gpio_force (gpio_force), .sysclk_en (sysclk_en), .vec_rd (vec_rd),
  .vec_addr (vec_addr), .pc_load (pc_load), .rst_cause (rst_cause)
);

// File: tb/reset_sequencer_tb_top.sv
`timescale 1ns/1ps
module reset_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_tick = 1'b0;
  logic [1:0]  op_mode = 2'b00;
  logic        por_evt = 1'b0;
  logic        wdt_expired = 1'b0;
  logic        wdt_reset_en = 1'b0;
  logic        ext_rst_n = 1'b1;
  logic        dbg_ctl_rst = 1'b0;
  logic        dbg_pin_n = 1'b1;
  logic [7:0]  vec_data = 8'h00;
  logic        core_rst, dbg_rst, gpio_force, sysclk_en, vec_rd, pc_load;
  logic [15:0] vec_addr, pc_value;
  logic [4:0]  rst_cause;

  always #2.5 clk = ~clk;

  reset_sequencer dut_i (
    .clk (clk), .rst (rst), .osc_tick (osc_tick), .op_mode (op_mode),
    .por_evt (por_evt), .wdt_expired (wdt_expired), .wdt_reset_en (wdt_reset_en),
    .ext_rst_n (ext_rst_n), .dbg_ctl_rst (dbg_ctl_rst), .dbg_pin_n (dbg_pin_n),
    .vec_data (vec_data), .core_rst (core_rst), .dbg_rst (dbg_rst),
    .gpio_force (gpio_force), .sysclk_en (sysclk_en), .vec_rd (vec_rd),
    .vec_addr (vec_addr), .pc_load (pc_load), .pc_value (pc_value),
    .rst_cause (rst_cause)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  // vector bytes held in the bench's program memory
  logic [7:0] mem_hi = 8'h12;
  logic [7:0] mem_lo = 8'h34;

  // behavioural reference model
  bit [4:0]    s1 = '0, s2 = '0;
  int          m_phase = 1;   // 0 idle,1 osc,2 sys,3 hi rd,4 lo rd,5 load
  int          m_cnt = 0;
  int          m_cause = 0;
  bit          m_spare = 0;
  logic [7:0]  m_hi = '0;
  logic [15:0] m_pc = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    bit [4:0] raw;
    bit stop;
    int win;
    cyc++;
    started = 1;
    raw = {~dbg_pin_n, dbg_ctl_rst, ~ext_rst_n, wdt_expired & wdt_reset_en, por_evt};
    if (rst) begin
      s1 = '0; s2 = '0; m_phase = 1; m_cnt = 0; m_cause = 0;
      m_spare = 0; m_hi = '0; m_pc = '0;
    end else begin
      stop = (op_mode == 2'b10);
      win = -1;
      if (s2[0]) win = 0;
      else if (s2[2]) win = 2;
      else if (s2[1] && !stop) win = 1;
      else if (s2[3] && !stop) win = 3;
      else if (s2[4] && stop) win = 4;
      if (win >= 0) begin
        if (m_phase == 1 || m_phase == 2) m_spare = m_spare && (win == 3);
        else m_spare = (win == 3);
        m_phase = 1; m_cnt = 0; m_cause = win;
      end else begin
        case (m_phase)
          1: if (osc_tick) begin
               if (m_cnt == 65) begin m_phase = 2; m_cnt = 0; end
               else m_cnt++;
             end
          2: if (m_cnt == 15) begin m_phase = 3; m_cnt = 0; end
             else m_cnt++;
          3: begin m_hi = mem_hi; m_phase = 4; end
          4: begin m_pc = {m_hi, mem_lo}; m_phase = 5; end
          5: m_phase = 0;
          default: m_phase = 0;
        endcase
      end
      s2 = s1; s1 = raw;
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
    end
  end

  // compare on the falling edge, then serve the memory read
  always @(negedge clk) begin
    if (started) begin
      bit ec;
      ec = (m_phase == 1 || m_phase == 2);
      chk(core_rst == ec, "R2 core_rst", core_rst, ec);
      chk(sysclk_en == (m_phase != 1), "R3 sysclk_en", sysclk_en, m_phase != 1);
      chk(gpio_force == ec, "R4 gpio_force", gpio_force, ec);
      chk(dbg_rst == (ec && !m_spare), "R7 dbg_rst", dbg_rst, ec && !m_spare);
      chk(vec_rd == (m_phase == 3 || m_phase == 4), "R9 vec_rd", vec_rd, m_phase == 3 || m_phase == 4);
      if (m_phase == 3 || m_phase == 4)
        chk(vec_addr == ((m_phase == 4) ? 16'h0003 : 16'h0002), "R9 vec_addr", vec_addr,
            (m_phase == 4) ? 16'h0003 : 16'h0002);
      chk(pc_load == (m_phase == 5), "R10 pc_load", pc_load, m_phase == 5);
      chk(pc_value == m_pc, "R10 pc_value", pc_value, m_pc);
      chk(rst_cause == (5'd1 << m_cause), "R1 R5 R6 R8 rst_cause", rst_cause, 5'd1 << m_cause);
    end
    vec_data = !vec_rd ? 8'h00 : (vec_addr == 16'h0002) ? mem_hi :
               (vec_addr == 16'h0003) ? mem_lo : 8'hEE;
  end

  // slow oscillator: one tick every 4 clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    osc_tick = (tdiv == 0);
  end

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (m_phase == 0 && !core_rst) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic hold4();
    repeat (4) @(negedge clk);
  endtask

  // wait long enough for a request to have taken effect, then check
  task automatic expect_quiet(input string tag);
    repeat (8) @(negedge clk);
    chk(core_rst == 1'b0, tag, core_rst, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state: power-on sequence with cause bit 0 (R1)
    chk(core_rst && gpio_force && !sysclk_en, "R1 reset state", {core_rst, gpio_force, sysclk_en}, 3'b110);
    chk(rst_cause == 5'b00001, "R1 reset cause", rst_cause, 5'b00001);
    rst = 1'b0;
    wait_idle();
    chk(pc_value == 16'h1234, "R10 vector after power-on", pc_value, 16'h1234);

    // R5 external pin in normal mode; R12 latency
    mem_hi = 8'hA5; mem_lo = 8'h0F;
    ext_rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(core_rst == 1'b0, "R12 not yet reset", core_rst, 0);
    @(negedge clk);
    chk(core_rst == 1'b1, "R12 reset after two syncs", core_rst, 1);
    @(negedge clk); ext_rst_n = 1'b1;
    wait_idle();
    chk(pc_value == 16'hA50F, "R10 second vector", pc_value, 16'hA50F);

    // R5 watchdog without reset-enable: ignored
    wdt_expired = 1'b1; hold4(); wdt_expired = 1'b0;
    expect_quiet("R5 watchdog ignored when not enabled");
    // R5 watchdog enabled, halt mode
    op_mode = 2'b01; wdt_reset_en = 1'b1;
    wdt_expired = 1'b1; hold4(); wdt_expired = 1'b0;
    wait_idle();
    chk(rst_cause == 5'b00010, "R5 watchdog cause", rst_cause, 5'b00010);

    // R6 stop mode: watchdog and debug-control ignored
    op_mode = 2'b10;
    wdt_expired = 1'b1; hold4(); wdt_expired = 1'b0;
    expect_quiet("R6 watchdog ignored in stop");
    dbg_ctl_rst = 1'b1; hold4(); dbg_ctl_rst = 1'b0;
    expect_quiet("R6 debug-control ignored in stop");
    // R6 debug pin accepted in stop
    dbg_pin_n = 1'b0; hold4(); dbg_pin_n = 1'b1;
    wait_idle();
    chk(rst_cause == 5'b10000, "R6 debug pin cause", rst_cause, 5'b10000);

    // R6 debug pin ignored in normal mode
    op_mode = 2'b00;
    dbg_pin_n = 1'b0; hold4(); dbg_pin_n = 1'b1;
    expect_quiet("R6 debug pin ignored outside stop");

    // R7 debug-control reset spares the debug unit
    dbg_ctl_rst = 1'b1; hold4(); dbg_ctl_rst = 1'b0;
    chk(core_rst && !dbg_rst, "R7 debug unit spared", {core_rst, dbg_rst}, 2'b10);
    repeat (40) @(negedge clk);
    // R11 R7: pin request during hold restarts and resets the debug unit
    ext_rst_n = 1'b0; hold4(); ext_rst_n = 1'b1;
    chk(dbg_rst == 1'b1, "R7 debug reset joins", dbg_rst, 1);
    wait_idle();

    // R8 priority: pin beats watchdog and debug-control
    dbg_ctl_rst = 1'b1; wdt_expired = 1'b1; ext_rst_n = 1'b0;
    hold4();
    dbg_ctl_rst = 1'b0; wdt_expired = 1'b0; ext_rst_n = 1'b1;
    wait_idle();
    chk(rst_cause == 5'b00100, "R8 pin wins", rst_cause, 5'b00100);
    // R8 watchdog beats debug-control
    dbg_ctl_rst = 1'b1; wdt_expired = 1'b1; hold4();
    dbg_ctl_rst = 1'b0; wdt_expired = 1'b0;
    wait_idle();
    chk(rst_cause == 5'b00010, "R8 watchdog beats debug-control", rst_cause, 5'b00010);
    // R1 power beats all, in stop mode
    op_mode = 2'b10;
    por_evt = 1'b1; ext_rst_n = 1'b0; dbg_pin_n = 1'b0; hold4();
    por_evt = 1'b0; ext_rst_n = 1'b1; dbg_pin_n = 1'b1;
    wait_idle();
    chk(rst_cause == 5'b00001, "R1 power wins", rst_cause, 5'b00001);

    // R11 restart during system-clock phase
    op_mode = 2'b00;
    ext_rst_n = 1'b0; hold4(); ext_rst_n = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sysclk_en && core_rst) break;
    end
    por_evt = 1'b1; @(negedge clk); por_evt = 1'b0;
    repeat (3) @(negedge clk);
    chk(core_rst && !sysclk_en, "R11 restart to oscillator phase", {core_rst, sysclk_en}, 2'b10);
    wait_idle();

    done = 1;
    finish_run();
  end
endmodule